// File: doc/BRIEF.md
# Multi-Mode Port Status LED Driver

This block turns the status of an eight-port Ethernet transceiver into LED drive signals. Each port reports four conditions: link up, activity, 100 Mb/s speed and full duplex. A two-bit output-mode select picks how these conditions reach the board. The serial format sends all 32 LED states in a repeating frame on one data pin, with a shift clock and a latch strobe. The parallel format gives every LED its own pin. The bicolor format gives each port a pair of pins that drive one two-colour LED.

A two-bit effect select shapes the activity indication in every format. Passthrough shows the raw activity input. Stretch holds the LED on for a fixed number of cycles after the last activity. Blink flashes a stretched activity LED from one shared divider, so every blinking LED stays in phase. All LED pins are active low. Any pin that the selected format does not use rests at its inactive level.

Top module: `led_status_drv`

## Requirements
- R1: Serial frame. The frame carries 32 bits. Bit k = 4p + j belongs to port p (0..7), with LED j: 0 link, 1 activity, 2 speed, 3 duplex. Bits go out in order k = 0 to 31. The data pin is active low (0 = LED lit). Data changes only when the shift clock falls, so it is stable at each rising edge.
- R2: After bit 31, the strobe is high for exactly one shift-clock period. The data pin is high (inactive) during the strobe. Bit 0 of the next frame follows at once, and that frame shows the LED states sampled when the strobe ended.
- R3: The shift-clock period is 2^SCLK_DIV_LOG2 system clock cycles.
- R4: Parallel mode (out_mode_i = 01). par_led_n_o[4p+j] is the inverse of LED j of port p, using the same j encoding as R1.
- R5: Bicolor mode (out_mode_i = 10). Pin A is bic_n_o[2p] and pin B is bic_n_o[2p+1]. With no link, both pins are high. With link and no activity, A is low and B is high. With link and activity, A and B swap at every blink-phase toggle. The two pins of a pair are never low together. The activity used here is raw when effect_i = 00 or 11, and stretched otherwise.
- R6: Stretch (effect_i = 01). The activity LED stays lit for HOLD_CYC cycles after the last cycle in which act_i was high. New activity during the hold restarts the hold time, including activity on the last held cycle.
- R7: Blink (effect_i = 10). While stretched activity is present, the activity LED toggles every BLINK_HALF cycles, and all ports are in phase. Without activity, the LED is dark.
- R8: Passthrough (effect_i = 00 or 11). The activity LED follows act_i in the same cycle.
- R9: Unused pins are idle. Outside serial mode, the serial data pin is high and the clock and strobe pins are low. Outside parallel mode, all parallel pins are high. Outside bicolor mode, all bicolor pins are high. Mode 11 leaves every pin idle.
- R10: Synchronous reset clears every stretch timer and restarts the serial frame. The strobe is low during reset and in the cycle after it.
- R11: The link, speed and duplex LEDs follow their inputs directly. The effect select does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| out_mode_i | input | 2 | 00 serial, 01 parallel, 10 bicolor, 11 all dark |
| effect_i | input | 2 | 00 passthrough, 01 stretch, 10 blink, 11 passthrough |
| link_i | input | NPORT | Link up per port |
| act_i | input | NPORT | Activity per port |
| speed_i | input | NPORT | 100 Mb/s per port |
| duplex_i | input | NPORT | Full duplex per port |
| ser_data_o | output | 1 | Serial LED data, active low |
| ser_clk_o | output | 1 | Serial shift clock |
| ser_strobe_o | output | 1 | Serial latch strobe |
| par_led_n_o | output | 4*NPORT | One active-low pin per LED |
| bic_n_o | output | 2*NPORT | Active-low bicolor pair per port |

## Verification
A stretch timer can be reloaded by new activity in the same cycle that its countdown would reach zero. The hazard is a one-cycle dark gap, or a timer that wraps around. The bench provokes this by raising activity on exactly the last held cycle. It then requires the LED to stay lit without a break for a full new hold time, and to go dark exactly one cycle after that. The bench also checks the bicolor pair across blink toggles while activity is held. This confirms that the swap of the two pins and the activity hold never leave both pins lit.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

  typedef enum logic [1:0] {
    OM_SERIAL   = 2'b00,
    OM_PARALLEL = 2'b01,
    OM_BICOLOR  = 2'b10,
    OM_DARK     = 2'b11
  } out_mode_e;

  typedef enum logic [1:0] {
    FX_NONE    = 2'b00,
    FX_STRETCH = 2'b01,
    FX_BLINK   = 2'b10,
    FX_ALT     = 2'b11
  } effect_e;

  // Active-high lit state of the activity LED for a given effect.
  function automatic logic act_lit(effect_e fx, logic raw, logic held, logic phase);
    case (fx)
      FX_STRETCH: return held;
      FX_BLINK:   return held & phase;
      default:    return raw;
    endcase
  endfunction

  // Lit state of a bicolor pair, {B, A}.
  function automatic logic [1:0] pair_lit(logic link, logic act, logic phase);
    if (!link)     return 2'b00;
    else if (!act) return 2'b01;
    else           return phase ? 2'b01 : 2'b10;
  endfunction

endpackage

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int NPORT    = 8,
  parameter int HOLD_CYC = 5000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] act_i,
  output logic [NPORT-1:0] held_o
);
  localparam int TW = $clog2(HOLD_CYC + 1);
  localparam logic [TW-1:0] LOAD = TW'(HOLD_CYC);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [TW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst)                cnt_q <= '0;
      else if (act_i[p])      cnt_q <= LOAD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
    assign held_o[p] = act_i[p] | (cnt_q != '0);
  end
endmodule

// File: rtl/led_blink_div.sv
module led_blink_div #(
  parameter int HALF_CYC = 12500000
) (
  input  logic clk,
  input  logic rst,
  output logic phase_o,
  output logic toggle_o
);
  localparam int BW = $clog2(HALF_CYC);
  localparam logic [BW-1:0] LAST = BW'(HALF_CYC - 1);

  logic [BW-1:0] cnt_q;
  logic          phase_q;

  assign toggle_o = (cnt_q == LAST);
  assign phase_o  = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (toggle_o) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/led_serial_tx.sv
module led_serial_tx #(
  parameter int NBITS    = 32,
  parameter int DIV_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [NBITS-1:0] lit_i,
  output logic             sdata_o,
  output logic             sclk_o,
  output logic             strobe_o,
  output logic             fall_o
);
  localparam int SW = $clog2(NBITS + 1);
  localparam logic [SW-1:0] STB_SLOT = SW'(NBITS);

  logic [DIV_LOG2-1:0] div_q;
  logic [SW-1:0]       slot_q;
  logic [NBITS-1:0]    snap_q;
  logic [NBITS-1:0]    shifted;

  assign fall_o   = en_i & (&div_q);
  assign shifted  = snap_q >> slot_q;
  assign sclk_o   = en_i & div_q[DIV_LOG2-1];
  assign strobe_o = en_i & (slot_q == STB_SLOT);
  assign sdata_o  = ~(en_i & (slot_q != STB_SLOT) & shifted[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      slot_q <= '0;
      snap_q <= '0;
    end else if (!en_i) begin
      div_q  <= '0;
      slot_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      if (fall_o) begin
        if (slot_q == STB_SLOT) begin
          slot_q <= '0;
          snap_q <= lit_i;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
  import led_drv_pkg::*;
#(
  parameter int NPORT         = 8,
  parameter int HOLD_CYC      = 5000000,
  parameter int BLINK_HALF    = 12500000,
  parameter int SCLK_DIV_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         out_mode_i,
  input  logic [1:0]         effect_i,
  input  logic [NPORT-1:0]   link_i,
  input  logic [NPORT-1:0]   act_i,
  input  logic [NPORT-1:0]   speed_i,
  input  logic [NPORT-1:0]   duplex_i,
  output logic               ser_data_o,
  output logic               ser_clk_o,
  output logic               ser_strobe_o,
  output logic [4*NPORT-1:0] par_led_n_o,
  output logic [2*NPORT-1:0] bic_n_o
);
  localparam int NBITS = 4 * NPORT;

  out_mode_e        mode;
  effect_e          fx;
  logic [NPORT-1:0] act_held;
  logic             blink_phase;
  logic             blink_toggle;
  logic             ser_fall;
  logic [NBITS-1:0] lit_vec;
  logic [2*NPORT-1:0] pair_vec;

  assign mode = out_mode_e'(out_mode_i);
  assign fx   = effect_e'(effect_i);

  led_stretch #(.NPORT(NPORT), .HOLD_CYC(HOLD_CYC)) u_stretch (
    .clk(clk), .rst(rst), .act_i(act_i), .held_o(act_held)
  );

  led_blink_div #(.HALF_CYC(BLINK_HALF)) u_blink (
    .clk(clk), .rst(rst), .phase_o(blink_phase), .toggle_o(blink_toggle)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic bic_act;
    assign bic_act = (fx == FX_NONE || fx == FX_ALT) ? act_i[p] : act_held[p];
    assign lit_vec[4*p+0] = link_i[p];
    assign lit_vec[4*p+1] = act_lit(fx, act_i[p], act_held[p], blink_phase);
    assign lit_vec[4*p+2] = speed_i[p];
    assign lit_vec[4*p+3] = duplex_i[p];
    assign pair_vec[2*p +: 2] = pair_lit(link_i[p], bic_act, blink_phase);
  end

  led_serial_tx #(.NBITS(NBITS), .DIV_LOG2(SCLK_DIV_LOG2)) u_ser (
    .clk(clk), .rst(rst), .en_i(mode == OM_SERIAL), .lit_i(lit_vec),
    .sdata_o(ser_data_o), .sclk_o(ser_clk_o), .strobe_o(ser_strobe_o),
    .fall_o(ser_fall)
  );

  assign par_led_n_o = (mode == OM_PARALLEL) ? ~lit_vec  : '1;
  assign bic_n_o     = (mode == OM_BICOLOR)  ? ~pair_vec : '1;
endmodule

// File: rtl/led_status_drv_chk.sv
module led_status_drv_chk #(
  parameter int NPORT = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         out_mode_i,
  input logic [NPORT-1:0]   link_i,
  input logic [NPORT-1:0]   act_i,
  input logic [NPORT-1:0]   act_held,
  input logic               ser_data_o,
  input logic               ser_clk_o,
  input logic               ser_strobe_o,
  input logic [4*NPORT-1:0] par_led_n_o,
  input logic [2*NPORT-1:0] bic_n_o
);
  logic both_lit;
  always_comb begin
    both_lit = 1'b0;
    for (int p = 0; p < NPORT; p++)
      both_lit = both_lit | (~bic_n_o[2*p] & ~bic_n_o[2*p+1]);
  end

  AST_SER_IDLE: assert property (@(posedge clk) disable iff (rst)
    out_mode_i != 2'b00 |-> (ser_data_o && !ser_clk_o && !ser_strobe_o)); // R9
  AST_PAR_IDLE: assert property (@(posedge clk) disable iff (rst)
    out_mode_i != 2'b01 |-> (&par_led_n_o)); // R9
  AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !both_lit); // R5
  AST_PAIR_NOLINK: assert property (@(posedge clk) disable iff (rst)
    (out_mode_i == 2'b10 && !link_i[0]) |-> (bic_n_o[1:0] == 2'b11)); // R5
  AST_STROBE_DARK: assert property (@(posedge clk) disable iff (rst)
    ser_strobe_o |-> ser_data_o); // R2
  AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(act_i[0])) |-> act_held[0]); // R6
  AST_RST_STROBE: assert property (@(posedge clk)
    rst |=> !ser_strobe_o); // R10
endmodule

bind led_status_drv led_status_drv_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst(rst), .out_mode_i(out_mode_i), .link_i(link_i),
  .act_i(act_i), .act_held(act_held), .ser_data_o(ser_data_o),
  .ser_clk_o(ser_clk_o), .ser_strobe_o(ser_strobe_o),
  .par_led_n_o(par_led_n_o), .bic_n_o(bic_n_o)
);

// File: tb/led_status_drv_test.sv
module led_status_drv_test;
  localparam int NP   = 8;
  localparam int HOLD = 20;
  localparam int HALF = 16;
  localparam int DL2  = 2;
  localparam int SPER = 1 << DL2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    out_mode_i = 2'b00;
  logic [1:0]    effect_i = 2'b00;
  logic [NP-1:0] link_i = '0, act_i = '0, speed_i = '0, duplex_i = '0;
  logic          ser_data_o, ser_clk_o, ser_strobe_o;
  logic [4*NP-1:0] par_led_n_o;
  logic [2*NP-1:0] bic_n_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  led_status_drv #(.NPORT(NP), .HOLD_CYC(HOLD), .BLINK_HALF(HALF),
                   .SCLK_DIV_LOG2(DL2)) uut (
    .clk(clk), .rst(rst), .out_mode_i(out_mode_i), .effect_i(effect_i),
    .link_i(link_i), .act_i(act_i), .speed_i(speed_i), .duplex_i(duplex_i),
    .ser_data_o(ser_data_o), .ser_clk_o(ser_clk_o), .ser_strobe_o(ser_strobe_o),
    .par_led_n_o(par_led_n_o), .bic_n_o(bic_n_o)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lit_model(logic [NP-1:0] l, logic [NP-1:0] a,
                                            logic [NP-1:0] s, logic [NP-1:0] d);
    logic [31:0] v;
    for (int p = 0; p < NP; p++) begin
      v[4*p]   = l[p];
      v[4*p+1] = a[p];
      v[4*p+2] = s[p];
      v[4*p+3] = d[p];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic t_reset();  // R10
    out_mode_i = 2'b00; effect_i = 2'b01; act_i = '1;
    repeat (3) @(negedge clk);
    check(ser_strobe_o == 1'b0, "R10 strobe low in reset", 32'(ser_strobe_o), 0);
    rst = 1'b0; act_i = '0; out_mode_i = 2'b01;
    #1;
    check(par_led_n_o[1] == 1'b1, "R10 stretch timer cleared", 32'(par_led_n_o[1]), 1);
    @(negedge clk);
    check(par_led_n_o == ~32'h0, "R10 all dark after reset", par_led_n_o, ~32'h0);
  endtask

  task automatic t_parallel();  // R4 R8 R11
    out_mode_i = 2'b01; effect_i = 2'b00;
    link_i = 8'hA5; act_i = 8'h3C; speed_i = 8'h0F; duplex_i = 8'hF0;
    @(negedge clk);
    check(par_led_n_o == ~lit_model(link_i, act_i, speed_i, duplex_i), "R4 pattern 1",
          par_led_n_o, ~lit_model(link_i, act_i, speed_i, duplex_i));
    link_i = 8'h5A; act_i = 8'hC1; speed_i = 8'h99; duplex_i = 8'h26;
    #1;
    check(par_led_n_o == ~lit_model(link_i, act_i, speed_i, duplex_i), "R8 same-cycle passthrough",
          par_led_n_o, ~lit_model(link_i, act_i, speed_i, duplex_i));
    effect_i = 2'b11;
    #1;
    check(par_led_n_o == ~lit_model(link_i, act_i, speed_i, duplex_i), "R8 code 11 passthrough",
          par_led_n_o, ~lit_model(link_i, act_i, speed_i, duplex_i));
    effect_i = 2'b10; act_i = '0;
    repeat (HOLD + 2) @(negedge clk);
    check(par_led_n_o == ~lit_model(link_i, '0, speed_i, duplex_i), "R11 steady LEDs under blink",
          par_led_n_o, ~lit_model(link_i, '0, speed_i, duplex_i));
    link_i = '0; speed_i = '0; duplex_i = '0; effect_i = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_stretch();  // R6
    bit gap = 0;
    out_mode_i = 2'b01; effect_i = 2'b01;
    act_i[2] = 1'b1;
    @(negedge clk); act_i[2] = 1'b0;
    #1;
    check(par_led_n_o[9] == 1'b0, "R6 lit after pulse", 32'(par_led_n_o[9]), 0);
    repeat (HOLD - 1) @(negedge clk);
    check(par_led_n_o[9] == 1'b0, "R6 lit on last hold cycle", 32'(par_led_n_o[9]), 0);
    act_i[2] = 1'b1;  // retrigger on the last held cycle
    @(negedge clk); act_i[2] = 1'b0;
    for (int i = 0; i < HOLD; i++) begin
      #1;
      if (par_led_n_o[9] != 1'b0) gap = 1;
      @(negedge clk);
    end
    check(gap == 0, "R6 retrigger without gap", 32'(gap), 0);
    check(par_led_n_o[9] == 1'b1, "R6 dark after hold", 32'(par_led_n_o[9]), 1);
    act_i[2] = 1'b1;
    @(negedge clk); act_i[2] = 1'b0;
    repeat (8) @(negedge clk);
    act_i[2] = 1'b1;
    @(negedge clk); act_i[2] = 1'b0;
    repeat (HOLD - 1) @(negedge clk);
    check(par_led_n_o[9] == 1'b0, "R6 mid-hold retrigger", 32'(par_led_n_o[9]), 0);
    @(negedge clk);
    check(par_led_n_o[9] == 1'b1, "R6 dark after mid-hold retrigger", 32'(par_led_n_o[9]), 1);
  endtask

  task automatic t_blink();  // R7
    int last = -1, nchg = 0, bad = 0, skew = 0;
    logic prev;
    out_mode_i = 2'b01; effect_i = 2'b10; act_i = '1;
    @(negedge clk);
    prev = par_led_n_o[1];
    for (int i = 0; i < 5 * HALF; i++) begin
      @(negedge clk);
      if (par_led_n_o[1] != par_led_n_o[25]) skew++;
      if (par_led_n_o[1] != prev) begin
        if (last >= 0 && (i - last) != HALF) bad++;
        last = i; nchg++;
      end
      prev = par_led_n_o[1];
    end
    check(nchg >= 4 && bad == 0, "R7 toggle every half period", 32'(bad), 0);
    check(skew == 0, "R7 ports in phase", 32'(skew), 0);
    act_i = '0;
    repeat (HOLD + 1) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 2 * HALF; i++) begin
      @(negedge clk);
      if (par_led_n_o[1] != 1'b1) bad++;
    end
    check(bad == 0, "R7 dark without activity", 32'(bad), 0);
  endtask

  task automatic t_bicolor();  // R5
    int both = 0, nchg = 0, bad = 0, last = -1;
    logic prev;
    out_mode_i = 2'b10; effect_i = 2'b01; link_i = '0; act_i = '0;
    @(negedge clk);
    check(bic_n_o == '1, "R5 no link both dark", bic_n_o, 32'hFFFF);
    link_i = 8'h01;
    @(negedge clk);
    check(bic_n_o[1:0] == 2'b10, "R5 link idle A lit", 32'(bic_n_o[1:0]), 2);
    act_i = 8'h01;
    @(negedge clk);
    prev = bic_n_o[0];
    for (int i = 0; i < 4 * HALF; i++) begin
      @(negedge clk);
      if (bic_n_o[0] == bic_n_o[1]) both++;
      if (bic_n_o[0] != prev) begin
        if (last >= 0 && (i - last) != HALF) bad++;
        last = i; nchg++;
      end
      prev = bic_n_o[0];
    end
    check(both == 0, "R5 exactly one colour while active", 32'(both), 0);
    check(nchg >= 3 && bad == 0, "R5 alternation at blink rate", 32'(bad), 0);
    act_i = '0; link_i = '0;
    repeat (HOLD + 2) @(negedge clk);
  endtask

  task automatic t_serial();  // R1 R2 R3
    logic [31:0] expv, got;
    int guard = 0, nb = 0, stb_len = 0, rise_t = -1, per = 0, t = 0;
    logic pc, ps;
    out_mode_i = 2'b00; effect_i = 2'b00;
    link_i = 8'hC3; act_i = 8'h18; speed_i = 8'h6A; duplex_i = 8'h81;
    expv = lit_model(link_i, act_i, speed_i, duplex_i);
    ps = ser_strobe_o;
    do begin @(negedge clk); guard++; end
    while (!(ser_strobe_o && !ps && ((ps = ser_strobe_o) || 1)) && guard < 400
           && ((ps = ser_strobe_o) || 1));
    while (ser_strobe_o) begin stb_len++; @(negedge clk); end
    check(stb_len == SPER, "R2 strobe one shift period", 32'(stb_len), 32'(SPER));
    pc = ser_clk_o; got = '0;
    while (nb < 33 && t < 400) begin
      @(negedge clk); t++;
      if (ser_clk_o && !pc) begin
        if (rise_t >= 0 && per == 0) per = t - rise_t;
        rise_t = t;
        if (nb < 32) begin
          got[nb] = ~ser_data_o;
          if (ser_strobe_o) check(0, "R2 strobe during data", 1, 0);
        end else begin
          check(ser_strobe_o == 1'b1, "R2 strobe after bit 31", 32'(ser_strobe_o), 1);
          check(ser_data_o == 1'b1, "R2 data dark in strobe", 32'(ser_data_o), 1);
        end
        nb++;
      end
      pc = ser_clk_o;
    end
    check(got == expv, "R1 frame content and order", got, expv);
    check(per == SPER, "R3 shift clock period", 32'(per), 32'(SPER));
    link_i = '0; act_i = '0; speed_i = '0; duplex_i = '0;
  endtask

  task automatic t_idle();  // R9
    link_i = '1; speed_i = '1; duplex_i = '1; act_i = '1; effect_i = 2'b00;
    out_mode_i = 2'b01;
    repeat (10) @(negedge clk);
    check({ser_data_o, ser_clk_o, ser_strobe_o} == 3'b100, "R9 serial idle in parallel",
          32'({ser_data_o, ser_clk_o, ser_strobe_o}), 4);
    check(bic_n_o == '1, "R9 bicolor idle in parallel", bic_n_o, 32'hFFFF);
    out_mode_i = 2'b00;
    repeat (10) @(negedge clk);
    check(par_led_n_o == '1 && bic_n_o == '1, "R9 parallel and bicolor idle in serial",
          par_led_n_o, ~32'h0);
    out_mode_i = 2'b11;
    repeat (10) @(negedge clk);
    check(par_led_n_o == '1 && bic_n_o == '1 && ser_data_o && !ser_clk_o && !ser_strobe_o,
          "R9 mode 11 all dark", par_led_n_o, ~32'h0);
    link_i = '0; speed_i = '0; duplex_i = '0; act_i = '0;
  endtask

  initial begin
    t_reset();
    t_parallel();
    t_stretch();
    t_blink();
    t_bicolor();
    t_serial();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule